// File: doc/BRIEF.md
# Automatic RTS/CTS Flow Controller

This block adds automatic hardware handshaking to a UART. On the receive side it drives the active-low request-to-send pin from the receive FIFO fill level. It uses a pair of thresholds for each trigger-level setting, so the pin does not chatter while the fill level moves between them. On the transmit side it watches the active-low clear-to-send pin, which crosses a synchronizer first. It raises a transmit-hold signal at character boundaries only, so a character in flight is always finished.

The host enables each direction on its own. When automatic RTS is off, the pin follows a host-written modem-control bit. When automatic CTS is off, the transmitter is never held. A rising edge on the synchronized CTS line can also latch a status flag that serves as an interrupt source. The flag stays set until the host reads the modem status, which arrives here as a one-cycle clear strobe. The receive FIFO and the transmit shifter sit outside the block. The FIFO keeps accepting characters while RTS is deasserted, up to full.

Top module: `uart_autoflow_ctrl`

## Requirements
- R1: After a synchronous reset, `tx_hold` and `cts_flag` are 0 and the automatic-RTS state is "asserted", so `rts_n` is 0 while `auto_rts_en` is 1.
- R2: With `auto_rts_en`=1 and `rts_n` low, `rts_n` goes to 1 on the clock after `rx_count` is at or above the off threshold. The threshold is 4, 8, 14 or 14 for `trig_sel` codes 0, 1, 2 or 3 (trigger levels 1, 4, 8, 14).
- R3: With `auto_rts_en`=1 and `rts_n` high, `rts_n` returns to 0 on the clock after `rx_count` is at or below the on threshold. The threshold is 0, 1, 4 or 8 for `trig_sel` codes 0, 1, 2 or 3.
- R4: With `auto_rts_en`=1, while `rx_count` is strictly between the two thresholds, `rts_n` keeps its previous value.
- R5: With `auto_rts_en`=0, `rts_n` equals the inverse of `mcr_rts` in the same cycle. The automatic state is then cleared to "asserted".
- R6: `cts_n` passes through a two-flop synchronizer. A rise on `cts_n` cannot set `tx_hold` until the third rising clock edge after the change.
- R7: `tx_hold` rises only on the clock after a `char_done` strobe, and only while `auto_cts_en` is 1 and the synchronized CTS is 1.
- R8: `tx_hold` clears on the clock after the synchronized CTS reads 0. That is the third edge after `cts_n` falls.
- R9: While `auto_cts_en` is 0, `tx_hold` is 0 from the next clock on, whatever `cts_n` and `char_done` do.
- R10: A 0-to-1 edge on the synchronized CTS sets `cts_flag` when `auto_cts_en` and `cts_irq_en` are both 1. The flag holds until `cts_clr` pulses. If an edge and `cts_clr` arrive in the same cycle, the set takes priority.
- R11: With `cts_irq_en`=0, a CTS edge leaves `cts_flag` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_count | input | CNT_W (5) | Current receive FIFO fill level |
| trig_sel | input | 2 | Trigger select: 0=1, 1=4, 2=8, 3=14 characters |
| auto_rts_en | input | 1 | Enable automatic RTS |
| auto_cts_en | input | 1 | Enable automatic CTS |
| mcr_rts | input | 1 | Host RTS bit, used when automatic RTS is off (1 drives pin low) |
| cts_n | input | 1 | Asynchronous clear-to-send pin, active low |
| char_done | input | 1 | Strobe from transmitter: stop bit fully shifted out |
| cts_irq_en | input | 1 | Enable CTS status flag |
| cts_clr | input | 1 | Clear strobe from modem-status read |
| rts_n | output | 1 | Request-to-send pin, active low |
| tx_hold | output | 1 | Hold transmitter before the next character |
| cts_flag | output | 1 | Latched CTS edge status / interrupt source |

## Verification
The assertions assume that `char_done` comes from a real transmitter, at most once per character. They also assume that `rx_count` never goes beyond the FIFO depth. They treat `trig_sel` changes as legal at any time, because every threshold check is judged against the select value in force on the same cycle. The stimulus changes inputs only at falling edges and keeps `rx_count` within 0 to 16. It holds `cts_n` steady for at least three clocks around every check, so that synchronizer latency is the only delay the checks have to count.

// File: rtl/afc_pkg.sv
package afc_pkg;

    typedef enum logic [1:0] {
        TRIG_1  = 2'd0,
        TRIG_4  = 2'd1,
        TRIG_8  = 2'd2,
        TRIG_14 = 2'd3
    } trig_e;

    typedef struct packed {
        logic level;
        logic rise;
    } cts_evt_t;

    function automatic int unsigned rts_off_level(trig_e sel);
        case (sel)
            TRIG_1:  return 4;
            TRIG_4:  return 8;
            default: return 14;
        endcase
    endfunction

    function automatic int unsigned rts_on_level(trig_e sel);
        case (sel)
            TRIG_1:  return 0;
            TRIG_4:  return 1;
            TRIG_8:  return 4;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/afc_cts_sync.sv
module afc_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cts_n,
    output afc_pkg::cts_evt_t evt
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], cts_n};
            last_q <= sync_q[STAGES-1];
        end
    end

    always_comb begin
        evt.level = sync_q[STAGES-1];
        evt.rise  = sync_q[STAGES-1] & ~last_q;
    end
endmodule

// File: rtl/afc_rts_hyst.sv
module afc_rts_hyst #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] rx_count,
    input  afc_pkg::trig_e   trig,
    input  logic             auto_en,
    input  logic             mcr_rts,
    output logic             rts_n
);
    import afc_pkg::*;

    logic             off_q;
    logic [CNT_W-1:0] off_lvl;
    logic [CNT_W-1:0] on_lvl;

    always_comb begin
        off_lvl = CNT_W'(rts_off_level(trig));
        on_lvl  = CNT_W'(rts_on_level(trig));
    end

    always_ff @(posedge clk) begin
        if (rst || !auto_en) begin
            off_q <= 1'b0;
        end else if (!off_q && rx_count >= off_lvl) begin
            off_q <= 1'b1;
        end else if (off_q && rx_count <= on_lvl) begin
            off_q <= 1'b0;
        end
    end

    assign rts_n = auto_en ? off_q : ~mcr_rts;
endmodule

// File: rtl/afc_tx_gate.sv
module afc_tx_gate (
    input  logic clk,
    input  logic rst,
    input  logic auto_en,
    input  logic cts_level,
    input  logic char_done,
    output logic tx_hold
);
    always_ff @(posedge clk) begin
        if (rst || !auto_en || !cts_level) begin
            tx_hold <= 1'b0;
        end else if (char_done) begin
            tx_hold <= 1'b1;
        end
    end
endmodule

// File: rtl/afc_cts_status.sv
module afc_cts_status (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    input  logic auto_en,
    input  logic irq_en,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (rise && auto_en && irq_en) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_autoflow_ctrl.sv
module uart_autoflow_ctrl #(
    parameter int FIFO_DEPTH  = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [1:0]       trig_sel,
    input  logic             auto_rts_en,
    input  logic             auto_cts_en,
    input  logic             mcr_rts,
    input  logic             cts_n,
    input  logic             char_done,
    input  logic             cts_irq_en,
    input  logic             cts_clr,
    output logic             rts_n,
    output logic             tx_hold,
    output logic             cts_flag
);
    import afc_pkg::*;

    cts_evt_t cts_evt;
    trig_e    trig;

    assign trig = trig_e'(trig_sel);

    afc_cts_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst   (rst),
        .cts_n (cts_n),
        .evt   (cts_evt)
    );

    afc_rts_hyst #(.CNT_W(CNT_W)) rts_i (
        .clk      (clk),
        .rst      (rst),
        .rx_count (rx_count),
        .trig     (trig),
        .auto_en  (auto_rts_en),
        .mcr_rts  (mcr_rts),
        .rts_n    (rts_n)
    );

    afc_tx_gate gate_i (
        .clk       (clk),
        .rst       (rst),
        .auto_en   (auto_cts_en),
        .cts_level (cts_evt.level),
        .char_done (char_done),
        .tx_hold   (tx_hold)
    );

    afc_cts_status stat_i (
        .clk     (clk),
        .rst     (rst),
        .rise    (cts_evt.rise),
        .auto_en (auto_cts_en),
        .irq_en  (cts_irq_en),
        .clr     (cts_clr),
        .flag    (cts_flag)
    );
endmodule

// File: rtl/afc_checker.sv
module afc_checker #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] rx_count,
    input logic [1:0]       trig_sel,
    input logic             auto_rts_en,
    input logic             auto_cts_en,
    input logic             char_done,
    input logic             cts_irq_en,
    input logic             cts_clr,
    input logic             rts_n,
    input logic             tx_hold,
    input logic             cts_flag
);
    import afc_pkg::*;

    logic [CNT_W-1:0] off_lvl;
    logic [CNT_W-1:0] on_lvl;
    always_comb begin
        off_lvl = CNT_W'(rts_off_level(trig_e'(trig_sel)));
        on_lvl  = CNT_W'(rts_on_level(trig_e'(trig_sel)));
    end

    p_rts_off_r2: assert property (@(posedge clk) disable iff (rst)
        (auto_rts_en && !rts_n && rx_count >= off_lvl) |=> (!auto_rts_en || rts_n));

    p_rts_on_r3: assert property (@(posedge clk) disable iff (rst)
        (auto_rts_en && rts_n && rx_count <= on_lvl) |=> (!auto_rts_en || !rts_n));

    p_hold_at_boundary_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_hold) |-> $past(char_done) && $past(auto_cts_en));

    p_no_hold_disabled_r9: assert property (@(posedge clk) disable iff (rst)
        !auto_cts_en |=> !tx_hold);

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (cts_flag && !cts_clr) |=> cts_flag);

    p_flag_needs_enable_r11: assert property (@(posedge clk) disable iff (rst)
        (!cts_irq_en && !cts_flag) |=> !cts_flag);
endmodule

bind uart_autoflow_ctrl afc_checker #(.CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .rx_count    (rx_count),
    .trig_sel    (trig_sel),
    .auto_rts_en (auto_rts_en),
    .auto_cts_en (auto_cts_en),
    .char_done   (char_done),
    .cts_irq_en  (cts_irq_en),
    .cts_clr     (cts_clr),
    .rts_n       (rts_n),
    .tx_hold     (tx_hold),
    .cts_flag    (cts_flag)
);

// File: tb/uart_autoflow_ctrl_tb_top.sv
`timescale 1ns/1ps
module uart_autoflow_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] rx_count = '0;
    logic [1:0] trig_sel = '0;
    logic       auto_rts_en = 1'b0;
    logic       auto_cts_en = 1'b0;
    logic       mcr_rts = 1'b0;
    logic       cts_n = 1'b0;
    logic       char_done = 1'b0;
    logic       cts_irq_en = 1'b0;
    logic       cts_clr = 1'b0;
    logic       rts_n;
    logic       tx_hold;
    logic       cts_flag;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    uart_autoflow_ctrl dut_i (
        .clk(clk), .rst(rst), .rx_count(rx_count), .trig_sel(trig_sel),
        .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en), .mcr_rts(mcr_rts),
        .cts_n(cts_n), .char_done(char_done), .cts_irq_en(cts_irq_en),
        .cts_clr(cts_clr), .rts_n(rts_n), .tx_hold(tx_hold), .cts_flag(cts_flag)
    );

    typedef struct packed {
        logic [1:0] sel;
        logic [4:0] cnt;
        logic       exp;
    } vec_t;

    // R2/R3/R4 hysteresis walk; each row: trigger code, fill level, rts_n after one clock
    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 5'd0,  1'b0}, '{2'd0, 5'd3,  1'b0}, '{2'd0, 5'd4,  1'b1},
        '{2'd0, 5'd2,  1'b1}, '{2'd0, 5'd1,  1'b1}, '{2'd0, 5'd0,  1'b0},
        '{2'd1, 5'd5,  1'b0}, '{2'd1, 5'd8,  1'b1}, '{2'd1, 5'd3,  1'b1},
        '{2'd1, 5'd1,  1'b0}, '{2'd2, 5'd13, 1'b0}, '{2'd2, 5'd14, 1'b1},
        '{2'd2, 5'd5,  1'b1}, '{2'd2, 5'd4,  1'b0}, '{2'd3, 5'd12, 1'b0},
        '{2'd3, 5'd16, 1'b1}, '{2'd3, 5'd9,  1'b1}, '{2'd3, 5'd8,  1'b0}
    };

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    initial begin
        auto_rts_en = 1'b1;
        tick(3);
        @(negedge clk) rst = 1'b0;
        #1;
        check("R1 rts_n after reset", rts_n, 1'b0);
        check("R1 tx_hold after reset", tx_hold, 1'b0);
        check("R1 cts_flag after reset", cts_flag, 1'b0);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            trig_sel = VEC[v].sel;
            rx_count = VEC[v].cnt;
            tick(1);
            check($sformatf("R2/R3/R4 vector %0d", v), rts_n, VEC[v].exp);
        end

        // R5 manual RTS
        @(negedge clk);
        auto_rts_en = 1'b0; mcr_rts = 1'b1; rx_count = 5'd15; trig_sel = 2'd0;
        #1 check("R5 manual rts asserted", rts_n, 1'b0);
        @(negedge clk) mcr_rts = 1'b0;
        #1 check("R5 manual rts released", rts_n, 1'b1);
        tick(2);
        @(negedge clk) rx_count = 5'd2; auto_rts_en = 1'b1;
        #1 check("R5 state cleared on re-enable", rts_n, 1'b0);

        // R6/R7: cts rise with char_done held high
        @(negedge clk);
        auto_cts_en = 1'b1; cts_irq_en = 1'b1; char_done = 1'b1; cts_n = 1'b1;
        tick(2);
        check("R6 hold blocked by synchronizer", tx_hold, 1'b0);
        check("R6 flag not yet set", cts_flag, 1'b0);
        tick(1);
        check("R7 hold at boundary", tx_hold, 1'b1);
        check("R10 flag set on edge", cts_flag, 1'b1);
        @(negedge clk) char_done = 1'b0;
        tick(4);
        check("R10 flag sticky", cts_flag, 1'b1);

        // R8 release on cts low
        @(negedge clk) cts_n = 1'b0;
        tick(2);
        check("R8 hold before sync catches up", tx_hold, 1'b1);
        tick(1);
        check("R8 hold released", tx_hold, 1'b0);

        // R10 clear
        @(negedge clk) cts_clr = 1'b1;
        tick(1);
        check("R10 flag cleared", cts_flag, 1'b0);
        @(negedge clk) cts_clr = 1'b0;

        // R7 no char_done -> no hold
        @(negedge clk) cts_n = 1'b1;
        tick(5);
        check("R7 no hold without char_done", tx_hold, 1'b0);
        check("R10 flag set on second edge", cts_flag, 1'b1);

        // R9 auto cts disabled
        @(negedge clk) char_done = 1'b1;
        tick(1);
        check("R7 hold with char_done", tx_hold, 1'b1);
        @(negedge clk) auto_cts_en = 1'b0;
        tick(1);
        check("R9 hold dropped when disabled", tx_hold, 1'b0);
        tick(3);
        check("R9 hold stays low", tx_hold, 1'b0);
        @(negedge clk) char_done = 1'b0; auto_cts_en = 1'b1; cts_n = 1'b0; cts_clr = 1'b1;
        tick(1);
        @(negedge clk) cts_clr = 1'b0;
        tick(4);
        check("R10 flag cleared before R11", cts_flag, 1'b0);

        // R11 disabled interrupt
        @(negedge clk) cts_irq_en = 1'b0; cts_n = 1'b1;
        tick(5);
        check("R11 no flag without enable", cts_flag, 1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule